// File: doc/BRIEF.md
# Dual-Loop Reference Divider Chain

This block turns one reference clock into two comparison-rate strobes for a pair of phase-locked loops. A programmable common divider, ratio 8 to 1023, counts reference cycles and issues a one-cycle strobe at its terminal count. A 4-bit subdivider counts those common strobes, not reference cycles, and issues its own strobe on every Mth common strobe, where M runs from 1 to 16. Each subdivider strobe therefore lands in the same cycle as a common strobe, and the two comparison rates keep a fixed phase relation.

A route-select input chooses which loop gets which strobe. With the select high, the subdivided strobe drives the RF loop reference and the common strobe drives the IF loop reference. With the select low, the two are swapped. Each divider takes a new ratio only at its own terminal count, so a period that is already running always finishes at its old length.

Both dividers use the same two-state control: `DIV_ARM` and `DIV_RUN`. Synchronous reset forces `DIV_ARM` from any state. The ARM-to-RUN transition is unconditional and loads the ratio inputs. `DIV_RUN` holds itself. In `DIV_RUN` the terminal-count event reloads the counter and samples the ratio input again.

Top module: `refdiv_dual`

## Requirements
- R1: While `rst` is high, and for at least the first eight cycles after it falls, both `rf_ref` and `if_ref` are 0.
- R2: For a common ratio N in 8..1023 on `com_ratio`, the common strobe is high for exactly one cycle and repeats every N reference cycles.
- R3: A `com_ratio` value below 8, including 0, divides by 8.
- R4: `sub_code` holds M-1, so 4'b0000 divides by 1 and 4'b1111 by 16. The subdivided strobe is high on every Mth common strobe, in the same cycle, and never at any other time.
- R5: With `path_sel` = 1, `rf_ref` carries the subdivided strobe and `if_ref` carries the common strobe.
- R6: With `path_sel` = 0, `rf_ref` carries the common strobe and `if_ref` carries the subdivided strobe.
- R7: The `com_ratio` value present in the cycle of a common terminal count sets the length of the next common period. Changes at any other time do not shorten or lengthen the running period.
- R8: The `sub_code` value present at a subdivider terminal count sets how many common strobes the next subdivided period spans. A mid-period change has no effect on the running period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, up to 20 MHz |
| rst | input | 1 | Synchronous reset, active high |
| com_ratio | input | 10 | Common divide ratio, values below 8 act as 8 |
| sub_code | input | 4 | Subdivider ratio minus one |
| path_sel | input | 1 | 1: subdivided strobe to RF, common strobe to IF; 0: swapped |
| rf_ref | output | 1 | RF loop reference strobe, one cycle wide |
| if_ref | output | 1 | IF loop reference strobe, one cycle wide |

## Verification
The hardest case to reach is a ratio change that must land after one terminal count and before the next, because the latch point is invisible at the ports. The stimulus waits until it sees a strobe. It then changes the ratio in that same half-cycle, which is already past the latching edge. The next period must keep the old length, and the one after it must take the new value. The same method, counted in common strobes, covers the subdivider code. The sweep runs every subdivider code and a spread of common ratios, including the clamped values below 8 and the maximum of 1023.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

    // Shared control state of both divider stages
    typedef enum logic [0:0] {
        DIV_ARM = 1'b0,
        DIV_RUN = 1'b1
    } div_state_e;

endpackage

// File: rtl/refdiv_common.sv
module refdiv_common
    import refdiv_pkg::*;
#(
    parameter int CW   = 10,
    parameter int CMIN = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] ratio_i,
    output logic          tc_o,
    output logic [CW-1:0] lim_o
);
    localparam logic [CW-1:0] MIN_V = CW'(CMIN);
    localparam logic [CW-1:0] ONE_V = CW'(1);

    div_state_e    state_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim_q;

    function automatic logic [CW-1:0] clamp(input logic [CW-1:0] r);
        return (r < MIN_V) ? MIN_V : r;
    endfunction

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= DIV_ARM;
        end else begin
            unique case (state_q)
                DIV_ARM: state_q <= DIV_RUN;
                DIV_RUN: state_q <= DIV_RUN;
                default: state_q <= DIV_ARM;
            endcase
        end
    end

    // count and ratio registers
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            lim_q <= MIN_V;
        end else begin
            unique case (state_q)
                DIV_ARM: begin
                    cnt_q <= ONE_V;
                    lim_q <= clamp(ratio_i);
                end
                DIV_RUN: begin
                    if (tc_o) begin
                        cnt_q <= ONE_V;
                        lim_q <= clamp(ratio_i);
                    end else begin
                        cnt_q <= cnt_q + ONE_V;
                    end
                end
                default: begin
                    cnt_q <= '0;
                    lim_q <= MIN_V;
                end
            endcase
        end
    end

    assign tc_o  = (state_q == DIV_RUN) && (cnt_q == lim_q);
    assign lim_o = lim_q;

endmodule

// File: rtl/refdiv_sub.sv
module refdiv_sub
    import refdiv_pkg::*;
#(
    parameter int SW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en_i,
    input  logic [SW-1:0] code_i,
    output logic          tc_o
);
    localparam logic [SW-1:0] ONE_V = SW'(1);

    div_state_e    state_q;
    logic [SW-1:0] cnt_q;
    logic [SW-1:0] code_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= DIV_ARM;
        end else begin
            unique case (state_q)
                DIV_ARM: state_q <= DIV_RUN;
                DIV_RUN: state_q <= DIV_RUN;
                default: state_q <= DIV_ARM;
            endcase
        end
    end

    // event counter, advanced only by common strobes
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            code_q <= '0;
        end else begin
            unique case (state_q)
                DIV_ARM: begin
                    cnt_q  <= '0;
                    code_q <= code_i;
                end
                DIV_RUN: begin
                    if (en_i) begin
                        if (cnt_q == code_q) begin
                            cnt_q  <= '0;
                            code_q <= code_i;
                        end else begin
                            cnt_q <= cnt_q + ONE_V;
                        end
                    end
                end
                default: begin
                    cnt_q  <= '0;
                    code_q <= '0;
                end
            endcase
        end
    end

    assign tc_o = (state_q == DIV_RUN) && en_i && (cnt_q == code_q);

endmodule

// File: rtl/refdiv_route.sv
module refdiv_route (
    input  logic clk,
    input  logic rst,
    input  logic sel_i,
    input  logic com_i,
    input  logic sub_i,
    output logic rf_o,
    output logic if_o
);
    // registered crossbar: outputs never glitch on a select change
    always_ff @(posedge clk) begin
        if (rst) begin
            rf_o <= 1'b0;
            if_o <= 1'b0;
        end else begin
            rf_o <= sel_i ? sub_i : com_i;
            if_o <= sel_i ? com_i : sub_i;
        end
    end

endmodule

// File: rtl/refdiv_dual.sv
module refdiv_dual #(
    parameter int CW   = 10,
    parameter int SW   = 4,
    parameter int CMIN = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] com_ratio,
    input  logic [SW-1:0] sub_code,
    input  logic          path_sel,
    output logic          rf_ref,
    output logic          if_ref
);
    logic          com_tc;
    logic          sub_tc;
    logic [CW-1:0] com_lim;

    refdiv_common #(.CW(CW), .CMIN(CMIN)) u_com (
        .clk     (clk),
        .rst     (rst),
        .ratio_i (com_ratio),
        .tc_o    (com_tc),
        .lim_o   (com_lim)
    );

    refdiv_sub #(.SW(SW)) u_sub (
        .clk    (clk),
        .rst    (rst),
        .en_i   (com_tc),
        .code_i (sub_code),
        .tc_o   (sub_tc)
    );

    refdiv_route u_route (
        .clk   (clk),
        .rst   (rst),
        .sel_i (path_sel),
        .com_i (com_tc),
        .sub_i (sub_tc),
        .rf_o  (rf_ref),
        .if_o  (if_ref)
    );

endmodule

// File: rtl/refdiv_dual_chk.sv
module refdiv_dual_chk #(
    parameter int CW   = 10,
    parameter int CMIN = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          path_sel,
    input logic          rf_ref,
    input logic          if_ref,
    input logic          com_tc,
    input logic [CW-1:0] lim
);
    logic [CW:0] gap;

    always_ff @(posedge clk) begin
        if (rst || com_tc) gap <= '0;
        else if (gap != '1) gap <= gap + 1'b1;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!rf_ref && !if_ref));

    // R2
    rf_single_chk: assert property (@(posedge clk) disable iff (rst)
        rf_ref |=> !rf_ref);

    // R2
    if_single_chk: assert property (@(posedge clk) disable iff (rst)
        if_ref |=> !if_ref);

    // R3
    min_period_chk: assert property (@(posedge clk) disable iff (rst)
        com_tc |-> (gap >= (CW+1)'(CMIN - 1)));

    // R5
    sel_hi_align_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(path_sel) && rf_ref) |-> if_ref);

    // R6
    sel_lo_align_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(path_sel) && if_ref) |-> rf_ref);

    // R7
    ratio_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(lim) |-> ($past(com_tc) || $past(rst, 2)));

endmodule

bind refdiv_dual refdiv_dual_chk #(.CW(CW), .CMIN(CMIN)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .path_sel (path_sel),
    .rf_ref   (rf_ref),
    .if_ref   (if_ref),
    .com_tc   (com_tc),
    .lim      (com_lim)
);

// File: tb/tb_refdiv_dual.sv
module tb_refdiv_dual;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] com_ratio = 10'd8;
    logic [3:0] sub_code = 4'd0;
    logic       path_sel = 1'b1;
    logic       rf_ref;
    logic       if_ref;
    logic       cm;
    logic       sb;
    int         checks = 0;
    int         errors = 0;
    int         cyc = 0;

    always #10 clk = ~clk;

    refdiv_dual dut (
        .clk       (clk),
        .rst       (rst),
        .com_ratio (com_ratio),
        .sub_code  (sub_code),
        .path_sel  (path_sel),
        .rf_ref    (rf_ref),
        .if_ref    (if_ref)
    );

    // expected routing per R5/R6: common strobe and subdivided strobe
    assign cm = path_sel ? if_ref : rf_ref;
    assign sb = path_sel ? rf_ref : if_ref;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            errors = errors + 1;
            $display("FAIL watchdog: cycles %0d expected below %0d", cyc, 190000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int eff(input int n);
        return (n < 8) ? 8 : n;
    endfunction

    task automatic next_strobe(output int gap, output bit sub);
        gap = 0;
        do begin
            @(negedge clk);
            gap = gap + 1;
        end while (!cm && gap < 30000);
        sub = sb;
    endtask

    task automatic count_to_sub(output int k);
        int g;
        bit s;
        k = 0;
        do begin
            next_strobe(g, s);
            k = k + 1;
        end while (!s && k < 40);
    endtask

    task automatic do_reset(input int n, input int code, input bit sel);
        @(negedge clk);
        com_ratio = 10'(n);
        sub_code  = 4'(code);
        path_sel  = sel;
        rst = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check(!rf_ref && !if_ref, "R1", {30'd0, rf_ref, if_ref}, 0);
        end
        rst = 1'b0;
        repeat (6) begin
            @(negedge clk);
            check(!rf_ref && !if_ref, "R1", {30'd0, rf_ref, if_ref}, 0);
        end
    endtask

    task automatic sweep(input int n, input int code, input bit sel);
        int m;
        int g;
        int k;
        bit s;
        m = code + 1;
        do_reset(n, code, sel);
        count_to_sub(k);
        for (int i = 0; i < 2 * m; i++) begin
            next_strobe(g, s);
            check(g == eff(n), (n < 8) ? "R3 period" : "R2 period", g, eff(n));
            check(s == (((i + 1) % m) == 0), sel ? "R5 R4 sub pattern" : "R6 R4 sub pattern",
                  int'(s), int'(((i + 1) % m) == 0));
        end
    endtask

    initial begin
        int g;
        int k;
        bit s;

        // R4 every subdivider code, R5/R6 both routings
        for (int c = 0; c < 16; c++) sweep(8, c, c[0]);
        // R2/R3 spread of common ratios
        sweep(0, 2, 1'b1);
        sweep(3, 2, 1'b0);
        sweep(7, 1, 1'b1);
        sweep(9, 2, 1'b0);
        sweep(15, 3, 1'b1);
        sweep(64, 2, 1'b0);
        sweep(255, 1, 1'b1);
        sweep(1023, 1, 1'b0);
        sweep(9, 15, 1'b0);

        // R7: ratio change lands only at terminal count
        do_reset(10, 0, 1'b1);
        next_strobe(g, s);
        com_ratio = 10'd20;
        next_strobe(g, s);
        check(g == 10, "R7 old period kept", g, 10);
        com_ratio = 10'd12;
        next_strobe(g, s);
        check(g == 20, "R7 new period", g, 20);
        com_ratio = 10'd5;
        next_strobe(g, s);
        check(g == 12, "R7 old period kept", g, 12);
        next_strobe(g, s);
        check(g == 8, "R7 R3 clamped period", g, 8);

        // R8: subdivider code change lands only at its terminal count
        do_reset(8, 3, 1'b1);
        count_to_sub(k);
        sub_code = 4'd1;
        count_to_sub(k);
        check(k == 4, "R8 old sub span kept", k, 4);
        count_to_sub(k);
        check(k == 2, "R8 new sub span", k, 2);
        sub_code = 4'd15;
        count_to_sub(k);
        check(k == 2, "R8 old sub span kept", k, 2);
        count_to_sub(k);
        check(k == 16, "R8 new sub span", k, 16);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule